// File: doc/BRIEF.md
# Prefetching SAR Code Lookup

This block sits inside the loop of a successive-approximation converter and turns each trial point of the binary search into a calibrated DAC word. The table does not hold one word per SAR code. Each entry belongs to a parent node of the search tree and holds the two words its children could need, packed side by side. When the comparator resolves, the decision bit only has to pick one half of an entry that has already been read. The next DAC word therefore appears one clock after the decision, and no memory access sits in that path.

Every stored word carries a completion bit. A node is only ever visited at one known step, so this bit is fixed when the table is written: 0 for words used at odd steps and 1 for words used at even steps. The DONE output then flips each time a fresh word reaches the DAC. The parent entry for the first decision, and the first-step word, are kept in registers whenever the block is idle. This means the first decision can follow a start on the very next cycle. After the last decision the block reports completion and holds its outputs until the next start.

Top module: `sarlk_top`

## Requirements
- R1: While rst is high, and on the first cycle after it, dac_word, dac_done, busy, complete and sar_code are all 0.
- R2: A cycle with ld_en high writes ld_data into table entry ld_addr. In each entry, bits [WW-1:0] are the child used when the comparator bit is 0 and bits [2*WW-1:WW] are the child used when it is 1, where WW = DAC_W+1. Within a half, bit DAC_W is the completion bit and bits [DAC_W-1:0] are the DAC word. The low half of entry 0 is the first-step word.
- R3: One cycle after start, dac_word and dac_done show the first-step word, busy is 1, complete is 0 and sar_code is 0.
- R4: The parent entry used for the decision of step k is at the address formed by the earlier decisions b1..b(k-1), MSB first, followed by a single 1 and then zeros. The first decision uses address 100..0.
- R5: When cmp_valid is high in a busy cycle at step k < CODE_W, the next cycle shows the half of the step-k parent entry that cmp_bit selects. Decisions may arrive on back-to-back cycles.
- R6: The first-decision parent entry is kept in a register that tracks every write to its address. A decision on the cycle right after start uses the most recently written contents.
- R7: dac_done is the completion bit of the current word. With a table written by the odd-0/even-1 rule, it toggles with every new word of a conversion.
- R8: After the decision of step CODE_W, complete is 1, busy is 0, dac_word keeps the step-CODE_W word, and sar_code holds the decisions with the first one in the MSB. These values stay until the next start.
- R9: cmp_valid is ignored while busy is 0, both before a conversion and after completion. No output changes.
- R10: start takes priority over cmp_valid in the same cycle, and a start in the middle of a conversion restarts it from step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Table write strobe |
| ld_addr | input | CODE_W-1 | Table entry address |
| ld_data | input | 2*(DAC_W+1) | Double word to write |
| start | input | 1 | Begin a conversion |
| cmp_valid | input | 1 | Comparator decision strobe |
| cmp_bit | input | 1 | Comparator decision |
| dac_word | output | DAC_W | Current DAC word |
| dac_done | output | 1 | Completion bit of the current word |
| busy | output | 1 | Conversion in progress |
| complete | output | 1 | Final decision taken |
| sar_code | output | CODE_W | Decisions so far, first in MSB |

## Verification
The toggle assertion on dac_done assumes the table was written by the odd-0/even-1 rule. It also assumes no table write happens during a conversion. The bench therefore fills the whole table from a computed node-to-word function before converting. Whenever it rewrites the first-decision entry, it keeps the correct completion bits. All decisions arrive at the falling edge and never overlap a table write, and the overlapping cases (start with a strobe, a strobe after completion) are driven only in their own directed tests.

// File: rtl/sarlk_pkg.sv
package sarlk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;
endpackage

// File: rtl/sarlk_ram.sv
// Simple dual-port table: one write port, one registered read port.
module sarlk_ram #(
  parameter int AW = 6,
  parameter int DW = 22
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sarlk_hold.sv
// Idle pre-hold of the entries needed before any memory read can land:
// the first-step word (entry 0, low half) and the first parent entry.
module sarlk_hold #(
  parameter int AW = 6,
  parameter int WW = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [2*WW-1:0] wdata,
  output logic [WW-1:0]   root_word,
  output logic [2*WW-1:0] root_pair
);
  localparam logic [AW-1:0] ROOT_ADDR = AW'(1) << (AW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      root_word <= '0;
      root_pair <= '0;
    end else if (we) begin
      if (waddr == '0)       root_word <= wdata[WW-1:0];
      if (waddr == ROOT_ADDR) root_pair <= wdata;
    end
  end
endmodule

// File: rtl/sarlk_seq.sv
// Step sequencer: walking-one parent address, step index, decision code.
module sarlk_seq
  import sarlk_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        take,
  input  logic                        dbit,
  output phase_t                      phase,
  output logic [$clog2(CODE_W+1)-1:0] step_q,
  output logic                        fresh_q,
  output logic [CODE_W-2:0]           raddr,
  output logic [CODE_W-1:0]           code_q
);
  localparam int AW     = CODE_W - 1;
  localparam int STEP_W = $clog2(CODE_W + 1);
  localparam logic [AW-1:0] ROOT_ADDR = AW'(1) << (AW - 1);

  logic [AW-1:0] addr_q, mark_q, addr_nx;

  // replace the marker by the decision, move the marker one place down
  always_comb begin
    addr_nx = (addr_q & ~mark_q) | (dbit ? mark_q : '0) | (mark_q >> 1);
    raddr   = take ? addr_nx : addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      step_q  <= '0;
      addr_q  <= '0;
      mark_q  <= '0;
      fresh_q <= 1'b0;
      code_q  <= '0;
    end else if (start) begin
      phase   <= PH_RUN;
      step_q  <= STEP_W'(1);
      addr_q  <= ROOT_ADDR;
      mark_q  <= ROOT_ADDR;
      fresh_q <= 1'b1;
      code_q  <= '0;
    end else if (take) begin
      step_q  <= step_q + STEP_W'(1);
      addr_q  <= addr_nx;
      mark_q  <= mark_q >> 1;
      fresh_q <= 1'b0;
      code_q  <= {code_q[CODE_W-2:0], dbit};
      if (step_q == STEP_W'(CODE_W)) phase <= PH_FIN;
    end
  end

  // R4: walking marker never holds more than one bit
  a_r4_marker_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mark_q));

  // R8: completion is held until a new start
  a_r8_fin_held: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FIN && !start) |=> phase == PH_FIN);
endmodule

// File: rtl/sarlk_top.sv
module sarlk_top
  import sarlk_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int DAC_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [CODE_W-2:0]          ld_addr,
  input  logic [2*(DAC_W+1)-1:0]     ld_data,
  input  logic                       start,
  input  logic                       cmp_valid,
  input  logic                       cmp_bit,
  output logic [DAC_W-1:0]           dac_word,
  output logic                       dac_done,
  output logic                       busy,
  output logic                       complete,
  output logic [CODE_W-1:0]          sar_code
);
  localparam int AW     = CODE_W - 1;
  localparam int WW     = DAC_W + 1;
  localparam int EW     = 2 * WW;
  localparam int STEP_W = $clog2(CODE_W + 1);

  phase_t              phase;
  logic [STEP_W-1:0]   step_q;
  logic                fresh_q;
  logic [AW-1:0]       raddr;
  logic [EW-1:0]       rdata, root_pair, pair;
  logic [WW-1:0]       root_word, child, out_q;
  logic                take, last_step;

  assign take      = cmp_valid && (phase == PH_RUN) && !start;
  assign last_step = (step_q == STEP_W'(CODE_W));

  sarlk_seq #(.CODE_W(CODE_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .take(take), .dbit(cmp_bit),
    .phase(phase), .step_q(step_q), .fresh_q(fresh_q), .raddr(raddr),
    .code_q(sar_code)
  );

  sarlk_ram #(.AW(AW), .DW(EW)) ram_i (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .raddr(raddr), .rdata(rdata)
  );

  sarlk_hold #(.AW(AW), .WW(WW)) hold_i (
    .clk(clk), .rst(rst), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .root_word(root_word), .root_pair(root_pair)
  );

  // first decision comes from the pre-held entry, later ones from memory
  always_comb begin
    pair  = fresh_q ? root_pair : rdata;
    child = cmp_bit ? pair[EW-1:WW] : pair[WW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                     out_q <= '0;
    else if (start)              out_q <= root_word;
    else if (take && !last_step) out_q <= child;
  end

  assign dac_word = out_q[DAC_W-1:0];
  assign dac_done = out_q[DAC_W];
  assign busy     = (phase == PH_RUN);
  assign complete = (phase == PH_FIN);

  // R3: a start always opens a conversion
  a_r3_start_opens: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !complete && sar_code == '0);

  // R7: each new word flips the completion bit (table written by parity rule)
  a_r7_done_toggles: assert property (@(posedge clk) disable iff (rst)
    (take && !last_step) |=> dac_done != $past(dac_done));

  // R8: last decision closes the conversion and keeps the word
  a_r8_final_hold: assert property (@(posedge clk) disable iff (rst)
    (take && last_step) |=> complete && !busy && $stable(dac_word));

  // R9: without a running conversion the outputs stay put
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(dac_word) && $stable(dac_done) && $stable(sar_code));
endmodule

// File: tb/sarlk_top_tb_top.sv
module sarlk_top_tb_top;
  localparam int M       = 7;
  localparam int N       = 10;
  localparam int WW      = N + 1;
  localparam int EW      = 2 * WW;
  localparam int CLK_PER = 10;
  localparam int NVEC    = 8;

  // stimulus: decision pattern (first decision in MSB, also the expected code)
  // and whether an idle cycle separates decisions
  localparam logic [M-1:0] PATS [NVEC] = '{7'b0000000, 7'b1111111, 7'b1010101,
    7'b0101010, 7'b1001110, 7'b0110001, 7'b1100000, 7'b0011111};
  localparam bit GAPS [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [M-2:0] ld_addr = '0;
  logic [EW-1:0] ld_data = '0;
  logic start = 1'b0, cmp_valid = 1'b0, cmp_bit = 1'b0;
  logic [N-1:0] dac_word;
  logic dac_done, busy, complete;
  logic [M-1:0] sar_code;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int salt = 0;

  always #(CLK_PER/2) clk = ~clk;

  sarlk_top #(.CODE_W(M), .DAC_W(N)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .cmp_valid(cmp_valid), .cmp_bit(cmp_bit),
    .dac_word(dac_word), .dac_done(dac_done), .busy(busy),
    .complete(complete), .sar_code(sar_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference node word: completion bit by step parity, DAC value from trial code
  function automatic logic [WW-1:0] node_word(input int tc, input int s, input int sl);
    logic [N-1:0] v;
    v = N'((tc * 13 + 77 + sl) % (1 << N));
    return {(s % 2) == 0, v};
  endfunction

  // trial code of step s for a pattern: earlier decisions, then a one
  function automatic int trial(input logic [M-1:0] pat, input int s);
    int keep;
    keep = M - s + 1;
    return ((int'(pat) >> keep) << keep) | (1 << (M - s));
  endfunction

  function automatic logic [EW-1:0] entry(input int a, input int sl);
    int pt, mk, c0, c1, s;
    logic [WW-1:0] w0, w1;
    if (a == 0) return {{WW{1'b0}}, node_word(1 << (M - 1), 1, sl)};
    pt = a << 1;
    mk = pt & -pt;
    c0 = (pt & ~mk) | (mk >> 1);
    c1 = c0 | mk;
    s  = M - $clog2(mk >> 1);
    w0 = node_word(c0, s, sl);
    w1 = node_word(c1, s, sl);
    return {w1, w0};
  endfunction

  task automatic load(input int a, input int sl);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = (M-1)'(a); ld_data = entry(a, sl);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic exp_word(input string req, input logic [M-1:0] pat, input int s);
    logic [WW-1:0] w;
    w = node_word(trial(pat, s), s, salt);
    chk({req, " dac_word"}, int'(dac_word), int'(w[N-1:0]));
    chk("R7 dac_done", int'(dac_done), int'(w[N]));
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_conv(input logic [M-1:0] pat, input bit gap);
    do_start();
    exp_word("R3", pat, 1);
    chk("R3 busy", int'(busy), 1);
    chk("R3 complete", int'(complete), 0);
    for (int s = 1; s <= M; s++) begin
      cmp_valid = 1'b1; cmp_bit = pat[M-s];
      @(negedge clk);
      cmp_valid = 1'b0;
      if (s < M) exp_word("R4,R5", pat, s + 1);
      else begin
        exp_word("R8", pat, M);
        chk("R8 complete", int'(complete), 1);
        chk("R8 busy", int'(busy), 0);
        chk("R8 sar_code", int'(sar_code), int'(pat));
      end
      if (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dac_word", int'(dac_word), 0);
    chk("R1 busy", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dac_word", int'(dac_word), 0);
    chk("R1 dac_done", int'(dac_done), 0);
    chk("R1 complete", int'(complete), 0);
    chk("R1 sar_code", int'(sar_code), 0);

    // R9: strobe before any conversion is ignored
    cmp_valid = 1'b1; cmp_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    cmp_valid = 1'b0;
    chk("R9 idle dac_word", int'(dac_word), 0);
    chk("R9 idle busy", int'(busy), 0);
    chk("R9 idle sar_code", int'(sar_code), 0);

    // R2: fill table
    for (int a = 0; a < (1 << (M - 1)); a++) load(a, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) run_conv(PATS[i], GAPS[i]);

    // R9: strobes after completion are ignored
    cmp_valid = 1'b1; cmp_bit = ~PATS[NVEC-1][0];
    @(negedge clk); @(negedge clk);
    cmp_valid = 1'b0;
    exp_word("R9 after", PATS[NVEC-1], M);
    chk("R9 complete kept", int'(complete), 1);
    chk("R9 sar_code kept", int'(sar_code), int'(PATS[NVEC-1]));

    // R10: start wins over a strobe in the same cycle
    @(negedge clk); start = 1'b1; cmp_valid = 1'b1; cmp_bit = 1'b1;
    @(negedge clk); start = 1'b0; cmp_valid = 1'b0;
    exp_word("R10 same-cycle", 7'b1000000, 1);
    chk("R10 sar_code", int'(sar_code), 0);

    // R10: restart in the middle of a conversion
    for (int s = 1; s <= 3; s++) begin
      cmp_valid = 1'b1; cmp_bit = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
    end
    chk("R10 mid busy", int'(busy), 1);
    do_start();
    exp_word("R10 restart", 7'b0000000, 1);
    chk("R10 restart sar_code", int'(sar_code), 0);
    chk("R10 restart complete", int'(complete), 0);
    run_conv(7'b0110110, 1'b0);

    // R6: rewrite first-decision entry and the root word, decide at once
    salt = 5;
    load(0, salt);
    load(1 << (M - 2), salt);
    do_start();
    exp_word("R6 root", 7'b1000000, 1);
    cmp_valid = 1'b1; cmp_bit = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    exp_word("R6 prehold", 7'b1000000, 2);
    do_start();
    cmp_valid = 1'b1; cmp_bit = 1'b0;
    @(negedge clk);
    cmp_valid = 1'b0;
    exp_word("R6 prehold", 7'b0000000, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule